// File: doc/BRIEF.md
# Atomic Compare-Swap and Masked-Swap Unit

This unit performs one indivisible read-modify-write on a 32-bit memory word for a processor pipeline. Each operation takes an even/odd pair of data registers: the even register (called Dn here) carries the new data, and the odd register (Dn1) carries either the compare value or a bit mask. In compare-and-swap, the unit stores Dn when the memory word equals Dn1. Otherwise it writes the word back unchanged. In masked swap, it replaces only the memory bits selected by the mask with the matching bits of Dn. Both operations hand the original memory word back so it can be written to Dn.

The unit also forms the effective address from a base register and a 10-bit signed offset, and returns the updated base. Three addressing modes are supported: short offset, post-increment and pre-increment. The memory port carries whole little-endian words: bits 7:0 of the data bus are the byte at the word address. A lock output is held from the first read request until the write is acknowledged, so the memory arbiter can keep other requesters out.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Compare-and-swap whose memory word equals `dn1_in` writes `dn_in` to the word.
- R2: Compare-and-swap whose memory word differs from `dn1_in` still performs the write, and stores the original word unchanged.
- R3: Masked swap writes `(dn_in & dn1_in) | (old & ~dn1_in)`, where `old` is the word read.
- R4: Both operations present the original memory word on `result_word` during the single cycle in which `done` is high.
- R5: Short-offset mode (`op_code` 0x23 compare, 0x22 masked) accesses base+offset and returns `base_out` equal to the unchanged base.
- R6: Post-increment mode (0x03 compare, 0x02 masked) accesses the original base and returns base+offset on `base_out`.
- R7: Pre-increment mode (0x13 compare, 0x12 masked) accesses base+offset and returns that same value on `base_out`.
- R8: Any other `op_code` value is ignored. It causes no memory request, no `done` and no `busy`.
- R9: Each operation issues exactly one read and then exactly one write to the same address. `mem_lock` is high on every cycle in which `mem_req` is high.
- R10: The 10-bit offset is sign-extended, so offset 0x3FF subtracts one and offset 0x200 subtracts 512.
- R11: A `start` raised while `busy` is high is ignored, and no second operation follows.
- R12: After reset, `busy`, `done`, `mem_req` and `mem_lock` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op_code | input | 6 | Secondary opcode selecting the operation and the addressing mode |
| base_in | input | 32 | Base address register |
| offset | input | 10 | Signed offset |
| dn_in | input | 32 | Even register: new data |
| dn1_in | input | 32 | Odd register: compare value or mask |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result_word | output | 32 | Original memory word (valid with done) |
| base_out | output | 32 | Updated base register (valid with done) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_lock | output | 1 | Exclusive-access hold for the arbiter |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The hardest condition to produce is a second `start` arriving while the locked read-write pair is still in flight, and a slow memory makes it worse. The bench's memory model adds a programmable number of wait cycles before each acknowledge. It raises `start` again, with a different legal opcode, in the middle of such an operation. It then watches the memory port for several cycles after `done` to confirm that no extra read or write ever appears. Negative offsets and a failing compare are exercised under the same slow memory.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
    localparam int OP_W = 6;

    typedef enum logic [1:0] {
        MODE_POST  = 2'b00,
        MODE_PRE   = 2'b01,
        MODE_SHORT = 2'b10
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

    // bits [3:1] must be 3'b001; bits [5:4] give the mode (3 is unused); bit 0 = compare-swap
    function automatic logic op_legal(input logic [OP_W-1:0] code);
        return (code[3:1] == 3'b001) && (code[5:4] != 2'b11);
    endfunction
endpackage

// File: rtl/atomic_addr_gen.sv
module atomic_addr_gen
    import atomic_rmw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 10
) (
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    output logic [DATA_W-1:0] access_addr,
    output logic [DATA_W-1:0] next_base
);
    localparam int EXT_W = DATA_W - OFF_W;

    logic [DATA_W-1:0] off_ext;
    logic [DATA_W-1:0] sum;

    always_comb begin
        off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        sum     = base + off_ext;
        case (addr_mode_e'(mode))
            MODE_POST: begin
                access_addr = base;
                next_base   = sum;
            end
            MODE_PRE: begin
                access_addr = sum;
                next_base   = sum;
            end
            default: begin
                access_addr = sum;
                next_base   = base;
            end
        endcase
    end
endmodule

// File: rtl/atomic_merge.sv
module atomic_merge #(
    parameter int DATA_W = 32
) (
    input  logic              is_cas,
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] dn,
    input  logic [DATA_W-1:0] dn1,
    output logic [DATA_W-1:0] new_word
);
    always_comb begin
        if (is_cas) begin
            new_word = (old_word == dn1) ? dn : old_word;
        end else begin
            new_word = (dn & dn1) | (old_word & ~dn1);
        end
    end
endmodule

// File: rtl/atomic_seq.sv
module atomic_seq
    import atomic_rmw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              legal,
    input  logic              is_cas_in,
    input  logic [DATA_W-1:0] addr_in,
    input  logic [DATA_W-1:0] base_new_in,
    input  logic [DATA_W-1:0] dn_in,
    input  logic [DATA_W-1:0] dn1_in,
    input  logic [DATA_W-1:0] merged,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] old_word,
    output logic [DATA_W-1:0] base_out,
    output logic              cas_q,
    output logic [DATA_W-1:0] dn_q,
    output logic [DATA_W-1:0] dn1_q
);
    typedef struct packed {
        seq_state_e        st;
        logic              cas;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] old;
        logic [DATA_W-1:0] dn;
        logic [DATA_W-1:0] dn1;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start && legal) begin
                    r_d.st   = ST_READ;
                    r_d.cas  = is_cas_in;
                    r_d.addr = addr_in;
                    r_d.base = base_new_in;
                    r_d.dn   = dn_in;
                    r_d.dn1  = dn1_in;
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    r_d.old = mem_rdata;
                    r_d.st  = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack) r_d.st = ST_DONE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cas: 1'b0, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = (r_q.st == ST_DONE);
    assign mem_req   = (r_q.st == ST_READ) || (r_q.st == ST_WRITE);
    assign mem_we    = (r_q.st == ST_WRITE);
    assign mem_lock  = mem_req;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = merged;
    assign old_word  = r_q.old;
    assign base_out  = r_q.base;
    assign cas_q     = r_q.cas;
    assign dn_q      = r_q.dn;
    assign dn1_q     = r_q.dn1;

    // R9: read acknowledged leads straight into the write
    p_write_follows_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

    // R9: a pending request holds its address and direction
    p_req_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: completion is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: failed compare writes back the word read
    p_cas_miss_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && cas_q && (old_word != dn1_q)) |-> (mem_wdata == old_word));

    // R12: idle means a quiet memory port
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !mem_lock));

    // R11: a start while busy does not restart the sequence
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=> mem_we);
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atomic_rmw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] base_in,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] dn_in,
    input  logic [DATA_W-1:0] dn1_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result_word,
    output logic [DATA_W-1:0] base_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic              legal;
    logic [DATA_W-1:0] acc_addr;
    logic [DATA_W-1:0] nxt_base;
    logic              cas_q;
    logic [DATA_W-1:0] dn_q;
    logic [DATA_W-1:0] dn1_q;
    logic [DATA_W-1:0] merged;

    assign legal = op_legal(op_code);

    atomic_addr_gen #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_addr (
        .mode        (op_code[5:4]),
        .base        (base_in),
        .off         (offset),
        .access_addr (acc_addr),
        .next_base   (nxt_base)
    );

    atomic_merge #(.DATA_W(DATA_W)) u_merge (
        .is_cas   (cas_q),
        .old_word (result_word),
        .dn       (dn_q),
        .dn1      (dn1_q),
        .new_word (merged)
    );

    atomic_seq #(.DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .legal       (legal),
        .is_cas_in   (op_code[0]),
        .addr_in     (acc_addr),
        .base_new_in (nxt_base),
        .dn_in       (dn_in),
        .dn1_in      (dn1_in),
        .merged      (merged),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .done        (done),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_lock    (mem_lock),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .old_word    (result_word),
        .base_out    (base_out),
        .cas_q       (cas_q),
        .dn_q        (dn_q),
        .dn1_q       (dn1_q)
    );

    // R9: the lock covers every memory request
    p_lock_covers_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);

    // R8: an illegal opcode from idle starts nothing
    p_illegal_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !op_legal(op_code)) |=> !busy);
endmodule

// File: tb/sim_atomic_rmw_unit.sv
module sim_atomic_rmw_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  op_code = '0;
    logic [31:0] base_in = '0;
    logic [9:0]  offset = '0;
    logic [31:0] dn_in = '0;
    logic [31:0] dn1_in = '0;
    logic        busy, done, mem_req, mem_we, mem_lock;
    logic [31:0] result_word, base_out, mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack = 1'b0;

    int errors = 0;
    int checks = 0;
    int n_rd = 0, n_wr = 0, n_done = 0, lock_bad = 0;
    int lat = 0, wcnt = 0;
    logic [31:0] mem_word = '0;
    logic [31:0] rd_addr = '0, wr_addr = '0, wr_data = '0;

    always #4 clk = ~clk;

    atomic_rmw_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .base_in(base_in), .offset(offset), .dn_in(dn_in), .dn1_in(dn1_in),
        .busy(busy), .done(done), .result_word(result_word), .base_out(base_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    assign mem_rdata = mem_word;

    // memory model with programmable wait cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (wcnt >= lat) begin
                    mem_ack <= 1'b1;
                    wcnt    <= 0;
                    if (mem_we) begin
                        wr_addr <= mem_addr;
                        wr_data <= mem_wdata;
                        n_wr    <= n_wr + 1;
                    end else begin
                        rd_addr <= mem_addr;
                        n_rd    <= n_rd + 1;
                    end
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && mem_req && !mem_lock) lock_bad <= lock_bad + 1;
        if (rst_n && done) n_done <= n_done + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_rd = 0; n_wr = 0; n_done = 0; lock_bad = 0;
    endtask

    // one complete operation; extra_start raises a second start mid-flight
    task automatic run_op(input string tag, input logic [5:0] code,
                          input logic [31:0] base, input logic [9:0] off,
                          input logic [31:0] dn, input logic [31:0] dn1,
                          input logic [31:0] mem, input int wait_cyc,
                          input logic extra_start,
                          input logic [31:0] exp_addr, input logic [31:0] exp_base,
                          input logic [31:0] exp_wdata);
        int guard;
        @(negedge clk);
        clear_counts();
        lat = wait_cyc;
        mem_word = mem;
        op_code = code; base_in = base; offset = off; dn_in = dn; dn1_in = dn1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (extra_start) begin
            @(negedge clk);
            op_code = 6'h02; base_in = 32'hDEAD_0000; dn_in = '1; dn1_in = '1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk({tag, " R4 done seen"}, {31'b0, done}, 32'd1);
        chk({tag, " R4 result is old word"}, result_word, mem);
        chk({tag, " base_out"}, base_out, exp_base);
        repeat (6) @(negedge clk);
        chk({tag, " R9 read addr"}, rd_addr, exp_addr);
        chk({tag, " R9 write addr"}, wr_addr, exp_addr);
        chk({tag, " write data"}, wr_data, exp_wdata);
        chk({tag, " R9 one read"}, n_rd, 1);
        chk({tag, " R9 one write"}, n_wr, 1);
        chk({tag, " R9 lock held"}, lock_bad, 0);
        chk({tag, " R11 single done"}, n_done, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 busy", {31'b0, busy}, 0);
        chk("R12 done", {31'b0, done}, 0);
        chk("R12 mem_req", {31'b0, mem_req}, 0);
        chk("R12 mem_lock", {31'b0, mem_lock}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_cas_hit();
        run_op("R1 R5 cas hit short", 6'h23, 32'h0000_1000, 10'd8,
               32'hCAFE_F00D, 32'h1234_5678, 32'h1234_5678, 0, 1'b0,
               32'h0000_1008, 32'h0000_1000, 32'hCAFE_F00D);
    endtask

    task automatic t_cas_miss();
        run_op("R2 R6 cas miss post", 6'h03, 32'h0000_2000, 10'd4,
               32'hCAFE_F00D, 32'h1234_5678, 32'h1234_5679, 3, 1'b0,
               32'h0000_2000, 32'h0000_2004, 32'h1234_5679);
    endtask

    task automatic t_mswap();
        logic [31:0] dn = 32'hAAAA_5555, msk = 32'hFF00_0FF0, mw = 32'h1357_9BDF;
        run_op("R3 R7 mswap pre", 6'h12, 32'h0000_3000, 10'd16,
               dn, msk, mw, 1, 1'b0,
               32'h0000_3010, 32'h0000_3010, (dn & msk) | (mw & ~msk));
        run_op("R3 R5 mswap short", 6'h22, 32'h0000_3000, 10'd0,
               32'h0, 32'hFFFF_FFFF, 32'h8765_4321, 0, 1'b0,
               32'h0000_3000, 32'h0000_3000, 32'h0);
    endtask

    task automatic t_negative();
        run_op("R10 R7 cas pre -1", 6'h13, 32'h0000_4000, 10'h3FF,
               32'h1, 32'h2, 32'h2, 2, 1'b0,
               32'h0000_3FFF, 32'h0000_3FFF, 32'h1);
        run_op("R10 R6 mswap post -512", 6'h02, 32'h0000_4000, 10'h200,
               32'hFFFF_FFFF, 32'h0000_00FF, 32'h1111_1100, 0, 1'b0,
               32'h0000_4000, 32'h0000_3E00, 32'h1111_11FF);
    endtask

    task automatic t_illegal();
        @(negedge clk);
        clear_counts();
        op_code = 6'h24; start = 1'b1;
        @(negedge clk);
        chk("R8 busy after 0x24", {31'b0, busy}, 0);
        op_code = 6'h33;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        chk("R8 no reads", n_rd, 0);
        chk("R8 no writes", n_wr, 0);
        chk("R8 no done", n_done, 0);
    endtask

    task automatic t_busy_start();
        run_op("R11 start while busy", 6'h23, 32'h0000_5000, 10'd12,
               32'h0BAD_BEEF, 32'h0, 32'h7777_7777, 4, 1'b1,
               32'h0000_500C, 32'h0000_5000, 32'h7777_7777);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_cas_hit();
        t_cas_miss();
        t_mswap();
        t_negative();
        t_illegal();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule